// File: doc/BRIEF.md
# Byte-Serial Video Component Formatter

This block sits behind a narrow video input port and turns a stream of bytes into whole pixels. The bytes carry either packed colour (three bytes per pixel) or 4:2:2 luma/chroma (two chroma bytes shared by two luma bytes). A data-valid strobe marks the bytes that count. A line-start marker restarts the component count, so the grouping never drifts across lines.

Three configuration inputs set the behaviour. The first chooses between the colour format and the luma/chroma format. The second reverses the component order. The third replaces every component with its complement. All three are captured only on a line-start cycle, so a line is never formatted half one way and half another.

Each completed pixel appears on registered outputs with a single-cycle valid pulse. There is one output group for colour triplets and one for luma with its chroma pair.

Top module: `vf_byte_formatter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rgb_valid` and `ycc_valid` are 0 and every data output is 0.
- R2: In colour mode (`cfg_ycc`=0) with `cfg_order`=0, the three bytes of a group are red, green, blue. One cycle after the third byte is accepted, `rgb_valid` pulses and `rgb_data` holds red in bits [23:16], green in [15:8] and blue in [7:0].
- R3: In colour mode with `cfg_order`=1, the bytes of a group are blue, green, red, and they are placed in the same output fields as in R2.
- R4: In luma/chroma mode (`cfg_ycc`=1) with `cfg_order`=0, a group is Cb, Y0, Cr, Y1. One cycle after the Cr byte, `ycc_valid` pulses with Y0, Cb and Cr. One cycle after the Y1 byte, it pulses with Y1 and the same Cb and Cr.
- R5: In luma/chroma mode with `cfg_order`=1, the group is Cr, Y0, Cb, Y1, and it is output as in R4 with the chroma fields swapped to match.
- R6: With `cfg_rev`=1, every output component equals 255 minus the received byte.
- R7: A cycle with `line_start`=1 restarts the component count and discards any partial group. A byte accepted in that same cycle is the first component of the new group.
- R8: `cfg_ycc`, `cfg_order` and `cfg_rev` are sampled only in cycles with `line_start`=1. A valid byte in that cycle already uses the new settings. Changes at any other time have no effect on the outputs.
- R9: Bytes with `in_valid`=0 are ignored and do not advance the component count.
- R10: `rgb_valid` and `ycc_valid` are never high together, and `rgb_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ycc | input | 1 | Format select: 0 colour triplets, 1 luma/chroma 4:2:2 |
| cfg_order | input | 1 | Component order reversal |
| cfg_rev | input | 1 | Complement every component |
| line_start | input | 1 | Line-start marker, restarts grouping and samples configuration |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | COMP_W | Serial component byte |
| rgb_valid | output | 1 | Colour pixel pulse |
| rgb_data | output | 3*COMP_W | Colour pixel, red high, blue low |
| ycc_valid | output | 1 | Luma/chroma pixel pulse |
| y_data | output | COMP_W | Luma sample |
| cb_data | output | COMP_W | Blue-difference chroma |
| cr_data | output | COMP_W | Red-difference chroma |

## Verification
Restarting a line and completing a group can fall in the same cycle. This happens when `line_start` arrives with the byte that would have been the last of a partial group. The restart must win: no pixel may be emitted, and that byte must open the new group under the freshly sampled settings. The bench provokes this case directly with a two-byte partial group followed by a marked byte. It is also hit repeatedly by a long random stream. A behavioural queue model judges every cycle, checking the presence or absence of each valid pulse and the data carried with it.

// File: rtl/vf_pkg.sv
package vf_pkg;
  localparam int RGB_SLOTS  = 3;
  localparam int YCC_SLOTS  = 4;
  localparam int MAX_SLOTS  = 4;
  localparam int SLOT_PAIR  = 2;
  localparam int SLOT_LUMA2 = 3;

  typedef struct packed {
    logic ycc;
    logic swap;
    logic rev;
  } vf_cfg_t;
endpackage

// File: rtl/vf_cfg_latch.sv
module vf_cfg_latch
  import vf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_start,
  input  vf_cfg_t cfg_in,
  output vf_cfg_t cfg_q,
  output vf_cfg_t cfg_eff
);
  // settings move only on a line-start cycle; that cycle already uses them
  assign cfg_eff = line_start ? cfg_in : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (line_start) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/vf_phase_seq.sv
module vf_phase_seq
  import vf_pkg::*;
#(
  parameter int PH_W = $clog2(MAX_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_start,
  input  logic            in_valid,
  input  logic            ycc,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_eff,
  output logic            ev_rgb_done,
  output logic            ev_pair_done,
  output logic            ev_luma2
);
  localparam logic [PH_W-1:0] RGB_LAST  = PH_W'(RGB_SLOTS - 1);
  localparam logic [PH_W-1:0] YCC_LAST  = PH_W'(YCC_SLOTS - 1);
  localparam logic [PH_W-1:0] PAIR_SLOT = PH_W'(SLOT_PAIR);
  localparam logic [PH_W-1:0] L2_SLOT   = PH_W'(SLOT_LUMA2);

  logic [PH_W-1:0] last_slot;
  logic [PH_W-1:0] phase_nxt;

  assign phase_eff = line_start ? '0 : phase_q;
  assign last_slot = ycc ? YCC_LAST : RGB_LAST;

  assign ev_rgb_done  = in_valid && !ycc && (phase_eff == RGB_LAST);
  assign ev_pair_done = in_valid &&  ycc && (phase_eff == PAIR_SLOT);
  assign ev_luma2     = in_valid &&  ycc && (phase_eff == L2_SLOT);

  always_comb begin
    phase_nxt = phase_eff;
    if (in_valid) phase_nxt = (phase_eff == last_slot) ? '0 : phase_eff + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_nxt;
  end
endmodule

// File: rtl/vf_assemble.sv
module vf_assemble
  import vf_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int PH_W   = $clog2(MAX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COMP_W-1:0] in_byte,
  input  vf_cfg_t           cfg_eff,
  input  logic [PH_W-1:0]   phase_eff,
  input  logic              ev_rgb_done,
  input  logic              ev_pair_done,
  input  logic              ev_luma2,
  output logic              rgb_valid,
  output logic [3*COMP_W-1:0] rgb_data,
  output logic              ycc_valid,
  output logic [COMP_W-1:0] y_data,
  output logic [COMP_W-1:0] cb_data,
  output logic [COMP_W-1:0] cr_data
);
  localparam int HOLD = RGB_SLOTS - 1;

  function automatic logic [COMP_W-1:0] comp_fix(input logic [COMP_W-1:0] x, input logic rev);
    return rev ? ~x : x;
  endfunction

  function automatic logic [3*COMP_W-1:0] rgb_pack(input logic [COMP_W-1:0] first,
                                                   input logic [COMP_W-1:0] mid,
                                                   input logic [COMP_W-1:0] last,
                                                   input logic swap);
    return swap ? {last, mid, first} : {first, mid, last};
  endfunction

  logic [COMP_W-1:0] fixed;
  logic [COMP_W-1:0] slot_q [HOLD];

  assign fixed = comp_fix(in_byte, cfg_eff.rev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < HOLD; i++)
        if (in_valid && phase_eff == PH_W'(i)) slot_q[i] <= fixed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_valid <= 1'b0;
      rgb_data  <= '0;
    end else begin
      rgb_valid <= ev_rgb_done;
      if (ev_rgb_done) rgb_data <= rgb_pack(slot_q[0], slot_q[1], fixed, cfg_eff.swap);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ycc_valid <= 1'b0;
      y_data    <= '0;
      cb_data   <= '0;
      cr_data   <= '0;
    end else begin
      ycc_valid <= ev_pair_done || ev_luma2;
      if (ev_pair_done) begin
        y_data  <= slot_q[1];
        cb_data <= cfg_eff.swap ? fixed : slot_q[0];
        cr_data <= cfg_eff.swap ? slot_q[0] : fixed;
      end else if (ev_luma2) begin
        y_data  <= fixed;
      end
    end
  end
endmodule

// File: rtl/vf_byte_formatter.sv
module vf_byte_formatter
  import vf_pkg::*;
#(
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_ycc,
  input  logic                cfg_order,
  input  logic                cfg_rev,
  input  logic                line_start,
  input  logic                in_valid,
  input  logic [COMP_W-1:0]   in_byte,
  output logic                rgb_valid,
  output logic [3*COMP_W-1:0] rgb_data,
  output logic                ycc_valid,
  output logic [COMP_W-1:0]   y_data,
  output logic [COMP_W-1:0]   cb_data,
  output logic [COMP_W-1:0]   cr_data
);
  localparam int PH_W = $clog2(MAX_SLOTS);

  vf_cfg_t         cfg_in, cfg_q, cfg_eff;
  logic [PH_W-1:0] phase_q, phase_eff;
  logic            ev_rgb_done, ev_pair_done, ev_luma2;

  assign cfg_in = '{ycc: cfg_ycc, swap: cfg_order, rev: cfg_rev};

  vf_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .cfg_in(cfg_in), .cfg_q(cfg_q), .cfg_eff(cfg_eff)
  );

  vf_phase_seq #(.PH_W(PH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
    .ycc(cfg_eff.ycc), .phase_q(phase_q), .phase_eff(phase_eff),
    .ev_rgb_done(ev_rgb_done), .ev_pair_done(ev_pair_done), .ev_luma2(ev_luma2)
  );

  vf_assemble #(.COMP_W(COMP_W), .PH_W(PH_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_eff(cfg_eff), .phase_eff(phase_eff),
    .ev_rgb_done(ev_rgb_done), .ev_pair_done(ev_pair_done), .ev_luma2(ev_luma2),
    .rgb_valid(rgb_valid), .rgb_data(rgb_data),
    .ycc_valid(ycc_valid), .y_data(y_data), .cb_data(cb_data), .cr_data(cr_data)
  );
endmodule

// File: rtl/vf_byte_formatter_chk.sv
module vf_byte_formatter_chk
  import vf_pkg::*;
#(
  parameter int COMP_W = 8,
  parameter int PH_W   = $clog2(MAX_SLOTS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                line_start,
  input logic                in_valid,
  input logic [COMP_W-1:0]   in_byte,
  input vf_cfg_t             cfg_q,
  input logic                eff_swap,
  input logic                eff_rev,
  input logic [PH_W-1:0]     phase_q,
  input logic                ev_rgb_done,
  input logic                ev_pair_done,
  input logic                rgb_valid,
  input logic [3*COMP_W-1:0] rgb_data,
  input logic                ycc_valid,
  input logic [COMP_W-1:0]   cb_data,
  input logic [COMP_W-1:0]   cr_data
);
  a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(rgb_valid && ycc_valid));
  a_r10_rgb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |=> !rgb_valid);
  a_r2_rgb_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rgb_done |=> rgb_valid);
  a_r2_last_is_blue: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rgb_done && !eff_swap && !eff_rev |=> rgb_data[COMP_W-1:0] == $past(in_byte));
  a_r3_last_is_red: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rgb_done && eff_swap && !eff_rev |=> rgb_data[3*COMP_W-1:2*COMP_W] == $past(in_byte));
  a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rgb_done && !eff_swap && eff_rev |=> rgb_data[COMP_W-1:0] == ~$past(in_byte));
  a_r4_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_done |=> ycc_valid);
  a_r4_shared_chroma: assert property (@(posedge clk) disable iff (!rst_n)
    ycc_valid && $past(ycc_valid) |-> $stable(cb_data) && $stable(cr_data));
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !in_valid |=> phase_q == '0);
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(cfg_q));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !line_start |=> $stable(phase_q));
endmodule

bind vf_byte_formatter vf_byte_formatter_chk #(.COMP_W(COMP_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
  .in_byte(in_byte), .cfg_q(cfg_q), .eff_swap(cfg_eff.swap), .eff_rev(cfg_eff.rev),
  .phase_q(phase_q), .ev_rgb_done(ev_rgb_done), .ev_pair_done(ev_pair_done),
  .rgb_valid(rgb_valid), .rgb_data(rgb_data), .ycc_valid(ycc_valid),
  .cb_data(cb_data), .cr_data(cr_data)
);

// File: tb/sim_vf_byte_formatter.sv
module sim_vf_byte_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ycc = 1'b0, cfg_order = 1'b0, cfg_rev = 1'b0;
  logic        line_start = 1'b0, in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        rgb_valid, ycc_valid;
  logic [23:0] rgb_data;
  logic [7:0]  y_data, cb_data, cr_data;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  vf_byte_formatter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ycc(cfg_ycc), .cfg_order(cfg_order), .cfg_rev(cfg_rev),
    .line_start(line_start), .in_valid(in_valid), .in_byte(in_byte),
    .rgb_valid(rgb_valid), .rgb_data(rgb_data), .ycc_valid(ycc_valid),
    .y_data(y_data), .cb_data(cb_data), .cr_data(cr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: a byte list per group, config as integers
  int          m_ycc, m_ord, m_rev;
  logic [7:0]  grp[$];
  logic        e_rv, e_yv;
  logic [23:0] e_rgb;
  logic [7:0]  e_y, e_cb, e_cr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ycc = 0; m_ord = 0; m_rev = 0; grp.delete();
      e_rv = 0; e_yv = 0;
    end else begin
      e_rv = 0; e_yv = 0;
      if (line_start) begin
        m_ycc = cfg_ycc; m_ord = cfg_order; m_rev = cfg_rev; grp.delete();
      end
      if (in_valid) begin
        grp.push_back(m_rev != 0 ? 8'(255 - int'(in_byte)) : in_byte);
        if (m_ycc == 0 && grp.size() == 3) begin
          e_rgb = (m_ord == 0) ? {grp[0], grp[1], grp[2]} : {grp[2], grp[1], grp[0]};
          e_rv = 1; grp.delete();
        end else if (m_ycc == 1 && grp.size() == 3) begin
          e_cb = (m_ord == 0) ? grp[0] : grp[2];
          e_cr = (m_ord == 0) ? grp[2] : grp[0];
          e_y = grp[1]; e_yv = 1;
        end else if (m_ycc == 1 && grp.size() == 4) begin
          e_y = grp[3]; e_yv = 1; grp.delete();
        end
      end
    end
  end

  logic [23:0] rgb_cap[$];
  logic [23:0] ycc_cap[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (rgb_valid) rgb_cap.push_back(rgb_data);
      if (ycc_valid) ycc_cap.push_back({y_data, cb_data, cr_data});
      chk({cur_req, " model"},
          {6'd0, rgb_valid, ycc_valid, rgb_valid ? rgb_data : 24'd0},
          {6'd0, e_rv, e_yv, e_rv ? e_rgb : 24'd0});
      chk({cur_req, " model"}, ycc_valid ? {8'd0, y_data, cb_data, cr_data} : 32'd0,
          e_yv ? {8'd0, e_y, e_cb, e_cr} : 32'd0);
      chk("R10", {31'd0, rgb_valid && ycc_valid}, 32'd0);
    end
  end

  task automatic drive(input logic v, input logic ls, input logic [7:0] b);
    @(posedge clk); #1;
    in_valid = v; line_start = ls; in_byte = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h5A);
  endtask

  task automatic fresh();
    idle(3);
    rgb_cap.delete(); ycc_cap.delete();
  endtask

  task automatic set_cfg(input logic y, input logic o, input logic r);
    cfg_ycc = y; cfg_order = o; cfg_rev = r;
  endtask

  function automatic logic [31:0] at(input logic [23:0] q[$], input int i);
    return (q.size() > i) ? {8'd0, q[i]} : 32'hDEAD_BEEF;
  endfunction

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while in reset
    chk("R1", {rgb_valid, ycc_valid, rgb_data, y_data, cb_data, cr_data}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {rgb_valid, ycc_valid, rgb_data}, 32'd0);
    chk("R1", {8'd0, y_data, cb_data, cr_data}, 32'd0);

    cur_req = "R2"; set_cfg(0, 0, 0); fresh();
    drive(1, 1, 8'h11); drive(1, 0, 8'h22); drive(1, 0, 8'h33); idle(3);
    chk("R2", rgb_cap.size(), 1); chk("R2", at(rgb_cap, 0), 32'h112233);

    cur_req = "R3"; set_cfg(0, 1, 0); fresh();
    drive(1, 1, 8'h11); drive(1, 0, 8'h22); drive(1, 0, 8'h33); idle(3);
    chk("R3", rgb_cap.size(), 1); chk("R3", at(rgb_cap, 0), 32'h332211);

    cur_req = "R4"; set_cfg(1, 0, 0); fresh();
    drive(1, 1, 8'h40); drive(1, 0, 8'h50); drive(1, 0, 8'h60); drive(1, 0, 8'h70); idle(3);
    chk("R4", ycc_cap.size(), 2);
    chk("R4", at(ycc_cap, 0), 32'h504060); chk("R4", at(ycc_cap, 1), 32'h704060);

    cur_req = "R5"; set_cfg(1, 1, 0); fresh();
    drive(1, 1, 8'h40); drive(1, 0, 8'h50); drive(1, 0, 8'h60); drive(1, 0, 8'h70); idle(3);
    chk("R5", ycc_cap.size(), 2);
    chk("R5", at(ycc_cap, 0), 32'h506040); chk("R5", at(ycc_cap, 1), 32'h706040);

    cur_req = "R6"; set_cfg(0, 0, 1); fresh();
    drive(1, 1, 8'h00); drive(1, 0, 8'h0F); drive(1, 0, 8'hFF); idle(3);
    chk("R6", at(rgb_cap, 0), 32'hFFF000);
    set_cfg(1, 0, 1); fresh();
    drive(1, 1, 8'h01); drive(1, 0, 8'h02); drive(1, 0, 8'h03); drive(1, 0, 8'h04); idle(3);
    chk("R6", at(ycc_cap, 1), 32'hFBFEFC);

    // R7: restart lands on the byte that would have closed the partial group
    cur_req = "R7"; set_cfg(0, 0, 0); fresh();
    drive(1, 1, 8'h01); drive(1, 0, 8'h02);
    drive(1, 1, 8'hA1); drive(1, 0, 8'hA2); drive(1, 0, 8'hA3); idle(3);
    chk("R7", rgb_cap.size(), 1); chk("R7", at(rgb_cap, 0), 32'hA1A2A3);

    cur_req = "R8"; set_cfg(0, 0, 0); fresh();
    drive(1, 1, 8'h11); drive(1, 0, 8'h22); drive(1, 0, 8'h33);
    set_cfg(1, 1, 1); idle(2);
    drive(1, 0, 8'h44); drive(1, 0, 8'h55); drive(1, 0, 8'h66); idle(2);
    set_cfg(0, 1, 0);
    drive(1, 1, 8'h44); drive(1, 0, 8'h55); drive(1, 0, 8'h66); idle(3);
    chk("R8", rgb_cap.size(), 3);
    chk("R8", at(rgb_cap, 1), 32'h445566); chk("R8", at(rgb_cap, 2), 32'h665544);

    cur_req = "R9"; set_cfg(1, 0, 0); fresh();
    drive(1, 1, 8'h40); drive(0, 0, 8'hFF); drive(1, 0, 8'h50); drive(0, 0, 8'hAA);
    drive(0, 0, 8'hBB); drive(1, 0, 8'h60); drive(0, 0, 8'h00); drive(1, 0, 8'h70); idle(3);
    chk("R9", ycc_cap.size(), 2);
    chk("R9", at(ycc_cap, 0), 32'h504060); chk("R9", at(ycc_cap, 1), 32'h704060);

    // R10 plus all modes: long random stream judged by the model each cycle
    cur_req = "R10";
    for (int i = 0; i < 4000; i++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom));
      drive(($urandom % 4) != 0, ($urandom % 23) == 0, 8'($urandom));
    end
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule